// File: doc/BRIEF.md
# Multithreaded Fetch-to-Decode Micro-op Queue

This block is an in-order buffer between instruction fetch and decode in a core that runs several hardware threads. Fetch hands it a burst of micro-ops each cycle. Every micro-op carries an opaque payload and the ID of the thread it belongs to. Decode receives a burst from the oldest end each cycle. Because the queue sits between the two stages, fetch can run ahead while decode holds back one thread, and decode keeps receiving work while fetch waits on memory.

A thread can be flushed on its own. A squash for one thread ID removes every entry of that thread, including any arriving in the same cycle. The survivors close up with their order kept. Delivery to decode stops as soon as the oldest remaining entry belongs to a thread that decode is holding. Younger entries never overtake it. A restart input empties the whole queue. The block reports its free space as a count, and reports whether it is drained.

Top module: `fetch_uop_queue`

## Requirements
- R1: After reset, or in the cycle after `restart` is high at a clock edge, the queue holds nothing: `drained` is 1, `free_slots` equals DEPTH and no `deq_vld` bit is set. No micro-op presented in that cycle is kept.
- R2: `free_slots` is a register that always shows DEPTH minus the number of entries held after the most recent clock edge.
- R3: Fetch presents micro-ops in slots filled contiguously from slot 0, at most FETCH_W of them, and never more than `free_slots`. The block appends the accepted slots behind all older entries in slot order, so occupancy never goes above DEPTH.
- R4: At each edge, up to DEC_W entries leave from the head in program order. In the next cycle they appear on the `deq_*` slots, filled contiguously from slot 0, with the oldest in slot 0.
- R5: Removal stops at the first head entry whose thread has its `dec_stall` bit set (bit index = thread ID), even when younger entries belong to threads that are not stalled.
- R6: When `sq_vld` is high, every stored entry whose thread ID equals `sq_tid` is discarded before dequeue. Entries of other threads keep their relative order.
- R7: In a cycle with both a squash and an enqueue, incoming micro-ops tagged with `sq_tid` are dropped. Incoming micro-ops of other threads are still appended, closed up in slot order.
- R8: Free space is judged from the registered `free_slots`. Entries leaving at an edge make room only from the next cycle. Occupancy changes by accepted minus removed entries, so a full queue accepts nothing in the cycle its entries leave.
- R9: `drained` is 1 exactly when the queue holds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous flush of all entries |
| enq_vld | input | FETCH_W | Valid bit per incoming micro-op slot, contiguous from slot 0 |
| enq_tid | input | FETCH_W x TID_W | Thread ID per incoming slot |
| enq_data | input | FETCH_W x PAYLOAD_W | Payload per incoming slot |
| free_slots | output | CNT_W | Free entries available to fetch this cycle |
| sq_vld | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| dec_stall | input | THREADS | Per-thread hold from decode |
| deq_vld | output | DEC_W | Valid bit per outgoing slot |
| deq_tid | output | DEC_W x TID_W | Thread ID per outgoing slot |
| deq_data | output | DEC_W x PAYLOAD_W | Payload per outgoing slot |
| drained | output | 1 | Queue holds no entry |

## Verification
The assertions watch every cycle for the following:
- fetch staying within `free_slots`, with contiguous valid vectors on both sides;
- no delivered micro-op belonging to a thread that was stalled or squashed at the edge that released it;
- occupancy moving by exactly accepted minus delivered when no squash occurs;
- `restart` leaving an empty queue.

Order is a different matter. Only the bench's reference queue can show that survivors of a squash keep their order, that dropped arrivals vanish without disturbing other slots, and that a stalled head blocks the younger entries behind it. The bench compares every payload leaving the block against that model.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int unsigned DEF_DEPTH     = 32;
  localparam int unsigned DEF_FETCH_W   = 8;
  localparam int unsigned DEF_DEC_W     = 8;
  localparam int unsigned DEF_THREADS   = 4;
  localparam int unsigned DEF_PAYLOAD_W = 32;

  // width needed for a thread ID field
  function automatic int unsigned tid_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fq_compact.sv
// Packs the kept words of an array toward index 0, preserving order.
module fq_compact #(
  parameter int unsigned N    = 8,
  parameter int unsigned W    = 8,
  localparam int unsigned CW  = $clog2(N + 1)
) (
  input  logic [N-1:0][W-1:0] in_word,
  input  logic [N-1:0]        keep,
  output logic [N-1:0][W-1:0] out_word,
  output logic [CW-1:0]       out_cnt
);
  always_comb begin
    int p;
    p        = 0;
    out_word = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (keep[i]) begin
        out_word[p] = in_word[i];
        p = p + 1;
      end
    end
    out_cnt = CW'(p);
  end
endmodule

// File: rtl/fq_drain.sv
// Chooses how many head entries leave: stops at the first stalled thread.
module fq_drain #(
  parameter int unsigned DEC_W   = 8,
  parameter int unsigned THREADS = 4,
  parameter int unsigned TID_W   = 2,
  parameter int unsigned CNT_W   = 6,
  localparam int unsigned DCNT_W = $clog2(DEC_W + 1)
) (
  input  logic [CNT_W-1:0]             avail,
  input  logic [DEC_W-1:0][TID_W-1:0]  head_tid,
  input  logic [THREADS-1:0]           stall,
  output logic [DEC_W-1:0]             take,
  output logic [DCNT_W-1:0]            n_take
);
  always_comb begin
    logic blocked;
    int   n;
    blocked = 1'b0;
    n       = 0;
    take    = '0;
    for (int k = 0; k < int'(DEC_W); k++) begin
      if (!blocked && (k < int'(avail)) && !stall[head_tid[k]]) begin
        take[k] = 1'b1;
        n = n + 1;
      end else begin
        blocked = 1'b1;
      end
    end
    n_take = DCNT_W'(n);
  end
endmodule

// File: rtl/fetch_uop_queue.sv
module fetch_uop_queue #(
  parameter int unsigned DEPTH     = fq_pkg::DEF_DEPTH,
  parameter int unsigned FETCH_W   = fq_pkg::DEF_FETCH_W,
  parameter int unsigned DEC_W     = fq_pkg::DEF_DEC_W,
  parameter int unsigned THREADS   = fq_pkg::DEF_THREADS,
  parameter int unsigned PAYLOAD_W = fq_pkg::DEF_PAYLOAD_W,
  localparam int unsigned TID_W    = fq_pkg::tid_bits(THREADS),
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                restart,
  input  logic [FETCH_W-1:0]                  enq_vld,
  input  logic [FETCH_W-1:0][TID_W-1:0]       enq_tid,
  input  logic [FETCH_W-1:0][PAYLOAD_W-1:0]   enq_data,
  output logic [CNT_W-1:0]                    free_slots,
  input  logic                                sq_vld,
  input  logic [TID_W-1:0]                    sq_tid,
  input  logic [THREADS-1:0]                  dec_stall,
  output logic [DEC_W-1:0]                    deq_vld,
  output logic [DEC_W-1:0][TID_W-1:0]         deq_tid,
  output logic [DEC_W-1:0][PAYLOAD_W-1:0]     deq_data,
  output logic                                drained
);
  localparam int unsigned WORD_W = TID_W + PAYLOAD_W;
  localparam int unsigned FCNT_W = $clog2(FETCH_W + 1);
  localparam int unsigned DCNT_W = $clog2(DEC_W + 1);

  // storage: entry 0 is always the oldest
  logic [DEPTH-1:0][WORD_W-1:0] q_word, nxt_word;
  logic [CNT_W-1:0]             q_cnt, nxt_cnt;

  // stage 1: squash stored entries and close the gaps
  logic [DEPTH-1:0]             keep_old;
  logic [DEPTH-1:0][WORD_W-1:0] live_word;
  logic [CNT_W-1:0]             live_cnt;

  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_keep_old
    assign keep_old[i] = (i < int'(q_cnt)) &&
                         !(sq_vld && (q_word[i][WORD_W-1 -: TID_W] == sq_tid));
  end

  fq_compact #(.N(DEPTH), .W(WORD_W)) u_pack_old (
    .in_word (q_word),
    .keep    (keep_old),
    .out_word(live_word),
    .out_cnt (live_cnt)
  );

  // stage 2: pick the head entries that may leave
  logic [DEC_W-1:0][TID_W-1:0] head_tid;
  logic [DEC_W-1:0]            take;
  logic [DCNT_W-1:0]           n_take;

  for (genvar k = 0; k < int'(DEC_W); k++) begin : g_head
    assign head_tid[k] = live_word[k][WORD_W-1 -: TID_W];
  end

  fq_drain #(.DEC_W(DEC_W), .THREADS(THREADS), .TID_W(TID_W), .CNT_W(CNT_W)) u_drain (
    .avail   (live_cnt),
    .head_tid(head_tid),
    .stall   (dec_stall),
    .take    (take),
    .n_take  (n_take)
  );

  // stage 3: accept arrivals within the registered free count, drop squashed ones
  logic [FETCH_W-1:0][WORD_W-1:0] in_word, add_word;
  logic [FETCH_W-1:0]             keep_new;
  logic [FCNT_W-1:0]              add_cnt;

  for (genvar s = 0; s < int'(FETCH_W); s++) begin : g_keep_new
    assign in_word[s]  = {enq_tid[s], enq_data[s]};
    assign keep_new[s] = enq_vld[s] && (s < int'(free_slots)) &&
                         !(sq_vld && (enq_tid[s] == sq_tid));
  end

  fq_compact #(.N(FETCH_W), .W(WORD_W)) u_pack_new (
    .in_word (in_word),
    .keep    (keep_new),
    .out_word(add_word),
    .out_cnt (add_cnt)
  );

  // stage 4: shift out the taken head and append the arrivals
  always_comb begin
    int rem;
    rem      = int'(live_cnt) - int'(n_take);
    nxt_word = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (i + int'(n_take) < int'(DEPTH)) nxt_word[i] = live_word[i + int'(n_take)];
    end
    for (int s = 0; s < int'(FETCH_W); s++) begin
      if ((s < int'(add_cnt)) && (rem + s < int'(DEPTH))) nxt_word[rem + s] = add_word[s];
    end
    nxt_cnt = CNT_W'(rem + int'(add_cnt));
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      q_cnt      <= '0;
      free_slots <= CNT_W'(DEPTH);
      drained    <= 1'b1;
      deq_vld    <= '0;
    end else begin
      q_cnt      <= nxt_cnt;
      free_slots <= CNT_W'(DEPTH) - nxt_cnt;
      drained    <= (nxt_cnt == '0);
      deq_vld    <= take;
    end
  end

  // data path carries no reset
  always_ff @(posedge clk) begin
    q_word <= nxt_word;
    for (int k = 0; k < int'(DEC_W); k++) begin
      deq_tid[k]  <= live_word[k][WORD_W-1 -: TID_W];
      deq_data[k] <= live_word[k][PAYLOAD_W-1:0];
    end
  end
endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned FETCH_W   = 8,
  parameter int unsigned DEC_W     = 8,
  parameter int unsigned THREADS   = 4,
  parameter int unsigned PAYLOAD_W = 32,
  localparam int unsigned TID_W    = fq_pkg::tid_bits(THREADS),
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              restart,
  input logic [FETCH_W-1:0]                enq_vld,
  input logic [CNT_W-1:0]                  free_slots,
  input logic                              sq_vld,
  input logic [TID_W-1:0]                  sq_tid,
  input logic [THREADS-1:0]                dec_stall,
  input logic [DEC_W-1:0]                  deq_vld,
  input logic [DEC_W-1:0][TID_W-1:0]       deq_tid,
  input logic                              drained
);
  logic               past_ok, sq_vld_d, restart_d;
  logic [TID_W-1:0]   sq_tid_d;
  logic [THREADS-1:0] stall_d;
  int                 enq_n_d, free_d;

  always_ff @(posedge clk) begin
    past_ok   <= !rst;
    sq_vld_d  <= sq_vld;
    sq_tid_d  <= sq_tid;
    stall_d   <= dec_stall;
    restart_d <= restart;
    enq_n_d   <= $countones(enq_vld);
    free_d    <= int'(free_slots);
  end

  logic enq_contig, deq_contig;
  assign enq_contig = ((enq_vld + FETCH_W'(1)) & enq_vld) == '0;
  assign deq_contig = ((deq_vld + DEC_W'(1)) & deq_vld) == '0;

  p_free_bound_r2: assert property (@(posedge clk) disable iff (rst)
    int'(free_slots) <= int'(DEPTH));

  p_drained_r9: assert property (@(posedge clk) disable iff (rst)
    drained == (int'(free_slots) == int'(DEPTH)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    !restart |-> ($countones(enq_vld) <= int'(free_slots)));

  p_enq_contig_r3: assert property (@(posedge clk) disable iff (rst) enq_contig);

  p_deq_contig_r4: assert property (@(posedge clk) disable iff (rst) deq_contig);

  p_restart_r1: assert property (@(posedge clk) disable iff (rst)
    restart |=> (drained && (deq_vld == '0) && (int'(free_slots) == int'(DEPTH))));

  p_occupancy_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !sq_vld_d && !restart_d) |->
      (int'(free_slots) + enq_n_d == free_d + $countones(deq_vld)));

  for (genvar k = 0; k < int'(DEC_W); k++) begin : g_slot
    p_stall_head_r5: assert property (@(posedge clk) disable iff (rst)
      (past_ok && deq_vld[k]) |-> !stall_d[deq_tid[k]]);
    p_squash_r6: assert property (@(posedge clk) disable iff (rst)
      (past_ok && deq_vld[k] && sq_vld_d) |-> (deq_tid[k] != sq_tid_d));
  end
endmodule

bind fetch_uop_queue fq_checker #(
  .DEPTH(DEPTH), .FETCH_W(FETCH_W), .DEC_W(DEC_W),
  .THREADS(THREADS), .PAYLOAD_W(PAYLOAD_W)
) u_fq_chk (
  .clk(clk), .rst(rst), .restart(restart), .enq_vld(enq_vld),
  .free_slots(free_slots), .sq_vld(sq_vld), .sq_tid(sq_tid),
  .dec_stall(dec_stall), .deq_vld(deq_vld), .deq_tid(deq_tid),
  .drained(drained)
);

// File: tb/test_fetch_uop_queue.sv
`timescale 1ns/100ps
module test_fetch_uop_queue;
  localparam int DEPTH = 8, FW = 4, DW = 3, NT = 4, PW = 16;
  localparam int TW = 2, CW = $clog2(DEPTH + 1), WW = TW + PW;

  logic clk = 1'b0, rst = 1'b1, restart = 1'b0;
  logic [FW-1:0]         enq_vld = '0;
  logic [FW-1:0][TW-1:0] enq_tid = '0;
  logic [FW-1:0][PW-1:0] enq_data = '0;
  logic [CW-1:0]         free_slots;
  logic                  sq_vld = 1'b0;
  logic [TW-1:0]         sq_tid = '0;
  logic [NT-1:0]         dec_stall = '0;
  logic [DW-1:0]         deq_vld;
  logic [DW-1:0][TW-1:0] deq_tid;
  logic [DW-1:0][PW-1:0] deq_data;
  logic                  drained;

  always #2.5 clk = ~clk;

  fetch_uop_queue #(.DEPTH(DEPTH), .FETCH_W(FW), .DEC_W(DW), .THREADS(NT), .PAYLOAD_W(PW))
  i_fetch_uop_queue (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [WW-1:0] mq[$];
  logic [DW-1:0] exp_vld;
  logic [DW-1:0][WW-1:0] exp_word;
  int seq = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    enq_vld = '0; sq_vld = 1'b0; restart = 1'b0;
  endtask

  task automatic put(input int s, input int tid);
    enq_vld[s] = 1'b1; enq_tid[s] = TW'(tid); enq_data[s] = PW'(seq); seq++;
  endtask

  // reference queue update for one edge
  task automatic model_edge();
    int free_before, k;
    logic [WW-1:0] tmp[$];
    free_before = DEPTH - mq.size();
    exp_vld = '0;
    exp_word = '0;
    if (restart) begin mq.delete(); return; end
    if (sq_vld) begin
      foreach (mq[i]) if (mq[i][WW-1 -: TW] != sq_tid) tmp.push_back(mq[i]);
      mq = tmp;
    end
    k = 0;
    while (k < DW && mq.size() > 0 && !dec_stall[mq[0][WW-1 -: TW]]) begin
      exp_word[k] = mq.pop_front(); exp_vld[k] = 1'b1; k++;
    end
    for (int s = 0; s < FW; s++)
      if (enq_vld[s] && s < free_before && !(sq_vld && enq_tid[s] == sq_tid))
        mq.push_back({enq_tid[s], enq_data[s]});
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    clear_in();
    chk(int'(free_slots) == DEPTH - mq.size(), "R2 free_slots", free_slots, DEPTH - mq.size());
    chk(drained == (mq.size() == 0), "R9 drained", drained, mq.size() == 0);
    for (int k = 0; k < DW; k++) begin
      chk(deq_vld[k] == exp_vld[k] && (!exp_vld[k] || {deq_tid[k], deq_data[k]} == exp_word[k]),
          "R4 deq slot", {deq_vld[k], deq_tid[k], deq_data[k]}, {exp_vld[k], exp_word[k]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0, n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(int'(free_slots) == DEPTH, "R1 reset free", free_slots, DEPTH);
    chk(drained == 1'b1, "R1 reset drained", drained, 1);
    chk(deq_vld == '0, "R1 reset deq", deq_vld, 0);

    // R3: fill to capacity while decode holds all threads
    dec_stall = '1;
    while (mq.size() < DEPTH) begin
      for (int s = 0; s < FW; s++) put(s, s % NT);
      step();
    end
    chk(free_slots == '0, "R3 full", free_slots, 0);

    // R8: room made by leaving entries shows only one cycle later
    dec_stall = '0;
    step();
    chk(int'(free_slots) == 3, "R8 after drain", free_slots, 3);
    for (int s = 0; s < 3; s++) put(s, 1);
    step();
    chk(int'(free_slots) == 3, "R8 net enq+deq", free_slots, 3);

    // R5: stalled head blocks younger entries
    dec_stall = '1;
    for (int s = 0; s < 3; s++) put(s, (s + 2) % NT);
    step();
    dec_stall = '0;
    dec_stall[mq[0][WW-1 -: TW]] = 1'b1;
    step();
    chk(deq_vld == '0, "R5 head stall", deq_vld, 0);

    // R6: squash of thread 1 keeps the others in order
    dec_stall = '1;
    sq_vld = 1'b1; sq_tid = 2'd1;
    step();
    f0 = DEPTH - mq.size();
    chk(int'(free_slots) == f0, "R6 squash count", free_slots, f0);
    dec_stall = '0;
    repeat (4) step();

    // R7: squash plus enqueue in one cycle
    dec_stall = '1;
    f0 = int'(free_slots);
    put(0, 1); put(1, 0); put(2, 1); put(3, 3);
    sq_vld = 1'b1; sq_tid = 2'd1;
    step();
    chk(int'(free_slots) == f0 - 2, "R7 drop incoming", free_slots, f0 - 2);

    // R1: restart with a non-empty queue
    restart = 1'b1;
    step();
    chk(drained == 1'b1 && int'(free_slots) == DEPTH, "R1 restart", {drained, free_slots}, {1'b1, CW'(DEPTH)});

    // random mix
    for (int c = 0; c < 4000; c++) begin
      n = $urandom_range(0, FW);
      if (n > DEPTH - mq.size()) n = DEPTH - mq.size();
      for (int s = 0; s < n; s++) put(s, $urandom_range(0, NT - 1));
      for (int t = 0; t < NT; t++) dec_stall[t] = ($urandom_range(0, 3) == 0);
      sq_vld = ($urandom_range(0, 15) == 0);
      sq_tid = TW'($urandom_range(0, NT - 1));
      restart = ($urandom_range(0, 199) == 0);
      step();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule